// File: doc/BRIEF.md
# Literal Set and Shift Unit

This unit carries out the two literal-handling operations of a dock's instruction pipeline: the table-driven `set` operation and the 19-bit `shift` operation. A `set` selects one of four targets with a 2-bit destination code and one of several value sources with a 2-bit source code. It can load the outer loop count, the inner loop count, the acknowledge route register or the 37-bit word register, or it can hand a flag truth table to the flag unit. A `shift` pushes a 19-bit literal into the bottom of the word register, so a wide constant can be built from several shifts.

The sequencer presents an operation on the deck interface when the instruction comes on deck. The unit then extends the literal and holds it in a staging latch, together with the decoded codes. Some time later the sequencer raises `exec`, and the staged operation updates the registers at that clock edge. Predicate evaluation and loop gating stay in the sequencer. This unit reports back only the new register values and three one-cycle strobes: the word register was loaded, the outer count became zero, and a flag table was issued.

Top module: `literal_set_unit`

## Requirements
- R1: In the cycle after synchronous reset is released, every count, the infinite marker, the acknowledge route, the word register, the flag table and all three strobes read zero.
- R2: The literal and codes are captured at the clock edge where `deck_valid` is high. An execute uses the most recently captured operation, whatever `deck_*` carries at the execute edge. When `deck_valid` and `exec` are high in the same cycle, the previously staged operation executes and the new one is staged.
- R3: With `deck_shift`=0 and destination 00, source 00 loads the outer count from the low 6 literal bits. Source 01 loads it from the low 6 bits of the word register. Source 10 decrements it, holding at zero when it is already zero.
- R4: With destination 01, source 00 loads the inner count from the low 6 literal bits and source 01 loads it from the low 6 word bits. Both of these clear `inner_forever`. Source 10 sets `inner_forever` and clears the inner count.
- R5: Destination 10 with source 00 loads `ack_route` from the low 13 literal bits.
- R6: Destination 10 with source 01 loads the word register with the low 15 literal bits padded with zeros above. Source 10 pads those 15 bits with ones above instead.
- R7: With `deck_shift`=1, the word register becomes its old low 18 bits followed by the 19-bit literal, with the literal in bits 18:0.
- R8: Destination 11 with any source other than 11 raises `flag_we` for one cycle and presents the low 12 literal bits on `flag_table`. No count, route or word register changes.
- R9: Every load of the word register, whether by R6 or by R7, raises `word_loaded` for exactly the cycle after the execute edge.
- R10: Every write of the outer count by R3 whose resulting value is zero raises `unseal` for the cycle after the execute edge. This includes a decrement of a count that is already zero.
- R11: A `set` with source code 11 changes no register and raises no strobe, for every destination code.
- R12: Without `exec`, no register output changes, even when a new operation is staged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| deck_valid | input | 1 | Stage the operation on the deck inputs |
| deck_shift | input | 1 | 1 = shift operation, 0 = set operation |
| deck_src | input | 2 | Source code of a set |
| deck_dst | input | 2 | Destination code of a set |
| deck_lit | input | 19 | Literal field; a set uses bits 14:0 |
| exec | input | 1 | Execute the staged operation at this edge |
| outer_cnt | output | 6 | Outer loop count |
| inner_cnt | output | 6 | Inner loop count |
| inner_forever | output | 1 | Inner count is infinite |
| ack_route | output | 13 | Acknowledge route register |
| word_reg | output | 37 | Word (data) register |
| word_loaded | output | 1 | Word register was loaded (one cycle) |
| unseal | output | 1 | Outer count was written to zero (one cycle) |
| flag_we | output | 1 | Flag table issued (one cycle) |
| flag_table | output | 12 | Last flag truth table issued |

## Verification
Staging the next literal and executing the previous one can fall in the same cycle. A pipelined sequencer does exactly this when it brings the following instruction on deck while the current one executes. The bench provokes it by raising `deck_valid` with a new literal in the very cycle that `exec` is raised for an already staged operation. It then checks that the register state after that edge reflects only the older literal, and that a second `exec` applies the newer one. A model built from the source/destination rules predicts every register and strobe after each step of a sweep over all sixteen code pairs, several literal patterns, shifts and counter saturation.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
    parameter int WORD_W  = 37;
    parameter int SHIFT_W = 19;
    parameter int SET_W   = 15;
    parameter int PATH_W  = 13;
    parameter int CNT_W   = 6;
    parameter int FLAG_W  = 12;

    typedef enum logic [1:0] {
        SRC_LIT = 2'b00,
        SRC_REG = 2'b01,
        SRC_ALT = 2'b10,
        SRC_RSV = 2'b11
    } src_sel_e;

    typedef enum logic [1:0] {
        DST_OUTER = 2'b00,
        DST_INNER = 2'b01,
        DST_MISC  = 2'b10,
        DST_FLAG  = 2'b11
    } dst_sel_e;

    typedef struct packed {
        logic              is_shift;
        src_sel_e          src;
        dst_sel_e          dst;
        logic [WORD_W-1:0] lit;
    } staged_t;

    typedef struct packed {
        logic outer_wr;
        logic outer_dec;
        logic outer_from_reg;
        logic inner_wr;
        logic inner_inf;
        logic inner_from_reg;
        logic ack_wr;
        logic word_set;
        logic word_shift;
        logic flag_wr;
    } action_t;

    // Literal as it must stand in the staging latch.
    function automatic logic [WORD_W-1:0] stage_literal(
        input logic             is_shift,
        input src_sel_e         src,
        input dst_sel_e         dst,
        input logic [SHIFT_W-1:0] lit
    );
        logic [WORD_W-1:0] w;
        w = {{(WORD_W-SET_W){1'b0}}, lit[SET_W-1:0]};
        if (is_shift)
            w = {{(WORD_W-SHIFT_W){1'b0}}, lit};
        else if (dst == DST_MISC && src == SRC_ALT)
            w = {{(WORD_W-SET_W){1'b1}}, lit[SET_W-1:0]};
        return w;
    endfunction

    function automatic action_t decode_action(input staged_t s);
        action_t a;
        a = '0;
        if (s.is_shift) begin
            a.word_shift = 1'b1;
        end else if (s.src != SRC_RSV) begin
            case (s.dst)
                DST_OUTER: begin
                    a.outer_wr       = 1'b1;
                    a.outer_dec      = (s.src == SRC_ALT);
                    a.outer_from_reg = (s.src == SRC_REG);
                end
                DST_INNER: begin
                    a.inner_wr       = 1'b1;
                    a.inner_inf      = (s.src == SRC_ALT);
                    a.inner_from_reg = (s.src == SRC_REG);
                end
                DST_MISC: begin
                    a.ack_wr   = (s.src == SRC_LIT);
                    a.word_set = (s.src != SRC_LIT);
                end
                default: a.flag_wr = 1'b1;
            endcase
        end
        return a;
    endfunction
endpackage

// File: rtl/lsu_stage.sv
module lsu_stage
    import lsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               deck_valid,
    input  logic               deck_shift,
    input  src_sel_e           deck_src,
    input  dst_sel_e           deck_dst,
    input  logic [SHIFT_W-1:0] deck_lit,
    output staged_t            stg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            stg <= '0;
        end else if (deck_valid) begin
            stg.is_shift <= deck_shift;
            stg.src      <= deck_src;
            stg.dst      <= deck_dst;
            stg.lit      <= stage_literal(deck_shift, deck_src, deck_dst, deck_lit);
        end
    end
endmodule

// File: rtl/lsu_loop_counters.sv
module lsu_loop_counters
    import lsu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             exec,
    input  logic             outer_wr,
    input  logic             outer_dec,
    input  logic             outer_from_reg,
    input  logic             inner_wr,
    input  logic             inner_inf,
    input  logic             inner_from_reg,
    input  logic [CNT_W-1:0] lit_low,
    input  logic [CNT_W-1:0] word_low,
    output logic [CNT_W-1:0] outer_cnt,
    output logic [CNT_W-1:0] inner_cnt,
    output logic             inner_forever,
    output logic             unseal
);
    logic [CNT_W-1:0] outer_next;
    logic [CNT_W-1:0] inner_next;

    always_comb begin
        if (outer_dec)
            outer_next = (outer_cnt == '0) ? '0 : outer_cnt - CNT_W'(1);
        else if (outer_from_reg)
            outer_next = word_low;
        else
            outer_next = lit_low;
        inner_next = inner_from_reg ? word_low : lit_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            outer_cnt     <= '0;
            inner_cnt     <= '0;
            inner_forever <= 1'b0;
            unseal        <= 1'b0;
        end else begin
            unseal <= 1'b0;
            if (exec && outer_wr) begin
                outer_cnt <= outer_next;
                unseal    <= (outer_next == '0);
            end
            if (exec && inner_wr) begin
                inner_cnt     <= inner_inf ? '0 : inner_next;
                inner_forever <= inner_inf;
            end
        end
    end
endmodule

// File: rtl/lsu_word_regs.sv
module lsu_word_regs
    import lsu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              exec,
    input  logic              word_set,
    input  logic              word_shift,
    input  logic              ack_wr,
    input  logic              flag_wr,
    input  logic [WORD_W-1:0] lit,
    output logic [WORD_W-1:0] word_reg,
    output logic [PATH_W-1:0] ack_route,
    output logic              word_loaded,
    output logic              flag_we,
    output logic [FLAG_W-1:0] flag_table
);
    localparam int KEEP_W = WORD_W - SHIFT_W;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_reg    <= '0;
            ack_route   <= '0;
            word_loaded <= 1'b0;
            flag_we     <= 1'b0;
            flag_table  <= '0;
        end else begin
            word_loaded <= 1'b0;
            flag_we     <= 1'b0;
            if (exec) begin
                if (word_shift) begin
                    word_reg    <= {word_reg[KEEP_W-1:0], lit[SHIFT_W-1:0]};
                    word_loaded <= 1'b1;
                end else if (word_set) begin
                    word_reg    <= lit;
                    word_loaded <= 1'b1;
                end
                if (ack_wr)
                    ack_route <= lit[PATH_W-1:0];
                if (flag_wr) begin
                    flag_table <= lit[FLAG_W-1:0];
                    flag_we    <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/literal_set_unit.sv
module literal_set_unit
    import lsu_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               deck_valid,
    input  logic               deck_shift,
    input  logic [1:0]         deck_src,
    input  logic [1:0]         deck_dst,
    input  logic [SHIFT_W-1:0] deck_lit,
    input  logic               exec,
    output logic [CNT_W-1:0]   outer_cnt,
    output logic [CNT_W-1:0]   inner_cnt,
    output logic               inner_forever,
    output logic [PATH_W-1:0]  ack_route,
    output logic [WORD_W-1:0]  word_reg,
    output logic               word_loaded,
    output logic               unseal,
    output logic               flag_we,
    output logic [FLAG_W-1:0]  flag_table
);
    staged_t stg;
    action_t act;

    lsu_stage u_stage (
        .clk        (clk),
        .rst        (rst),
        .deck_valid (deck_valid),
        .deck_shift (deck_shift),
        .deck_src   (src_sel_e'(deck_src)),
        .deck_dst   (dst_sel_e'(deck_dst)),
        .deck_lit   (deck_lit),
        .stg        (stg)
    );

    always_comb act = decode_action(stg);

    lsu_loop_counters u_cnt (
        .clk            (clk),
        .rst            (rst),
        .exec           (exec),
        .outer_wr       (act.outer_wr),
        .outer_dec      (act.outer_dec),
        .outer_from_reg (act.outer_from_reg),
        .inner_wr       (act.inner_wr),
        .inner_inf      (act.inner_inf),
        .inner_from_reg (act.inner_from_reg),
        .lit_low        (stg.lit[CNT_W-1:0]),
        .word_low       (word_reg[CNT_W-1:0]),
        .outer_cnt      (outer_cnt),
        .inner_cnt      (inner_cnt),
        .inner_forever  (inner_forever),
        .unseal         (unseal)
    );

    lsu_word_regs u_word (
        .clk         (clk),
        .rst         (rst),
        .exec        (exec),
        .word_set    (act.word_set),
        .word_shift  (act.word_shift),
        .ack_wr      (act.ack_wr),
        .flag_wr     (act.flag_wr),
        .lit         (stg.lit),
        .word_reg    (word_reg),
        .ack_route   (ack_route),
        .word_loaded (word_loaded),
        .flag_we     (flag_we),
        .flag_table  (flag_table)
    );
endmodule

// File: rtl/lsu_checker.sv
module lsu_checker
    import lsu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              exec,
    input logic              stg_shift,
    input logic [1:0]        stg_src,
    input logic [1:0]        stg_dst,
    input logic [CNT_W-1:0]  outer_cnt,
    input logic [CNT_W-1:0]  inner_cnt,
    input logic              inner_forever,
    input logic [PATH_W-1:0] ack_route,
    input logic [WORD_W-1:0] word_reg,
    input logic              word_loaded,
    input logic              unseal,
    input logic              flag_we,
    input logic [FLAG_W-1:0] flag_table
);
    localparam int KEEP_W = WORD_W - SHIFT_W;

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !exec |=> $stable(outer_cnt) && $stable(inner_cnt) && $stable(inner_forever)
                  && $stable(ack_route) && $stable(word_reg) && $stable(flag_table));

    // R9
    load_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        word_loaded |-> $past(exec));

    // R7
    shift_keep_chk: assert property (@(posedge clk) disable iff (rst)
        exec && stg_shift |=> word_reg[WORD_W-1:SHIFT_W] == $past(word_reg[KEEP_W-1:0]));

    // R10
    unseal_zero_chk: assert property (@(posedge clk) disable iff (rst)
        unseal |-> outer_cnt == '0);

    // R3
    dec_floor_chk: assert property (@(posedge clk) disable iff (rst)
        exec && !stg_shift && stg_dst == 2'b00 && stg_src == 2'b10 && outer_cnt == '0
        |=> outer_cnt == '0 && unseal);

    // R11
    reserved_src_chk: assert property (@(posedge clk) disable iff (rst)
        exec && !stg_shift && stg_src == 2'b11
        |=> !word_loaded && !flag_we && !unseal && $stable(outer_cnt)
            && $stable(inner_cnt) && $stable(word_reg) && $stable(ack_route));

    // R8
    flag_alone_chk: assert property (@(posedge clk) disable iff (rst)
        flag_we |-> !word_loaded && !unseal);
endmodule

bind literal_set_unit lsu_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .exec          (exec),
    .stg_shift     (stg.is_shift),
    .stg_src       (stg.src),
    .stg_dst       (stg.dst),
    .outer_cnt     (outer_cnt),
    .inner_cnt     (inner_cnt),
    .inner_forever (inner_forever),
    .ack_route     (ack_route),
    .word_reg      (word_reg),
    .word_loaded   (word_loaded),
    .unseal        (unseal),
    .flag_we       (flag_we),
    .flag_table    (flag_table)
);

// File: tb/sim_literal_set_unit.sv
`timescale 1ns/1ps
module sim_literal_set_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic        deck_valid, deck_shift, exec;
    logic [1:0]  deck_src, deck_dst;
    logic [18:0] deck_lit;
    logic [5:0]  outer_cnt, inner_cnt;
    logic        inner_forever, word_loaded, unseal, flag_we;
    logic [12:0] ack_route;
    logic [36:0] word_reg;
    logic [11:0] flag_table;

    int checks = 0;
    int errors = 0;

    logic [5:0]  m_outer, m_inner;
    logic        m_inf, e_load, e_unseal, e_flag;
    logic [12:0] m_ack;
    logic [36:0] m_word;
    logic [11:0] m_flags;

    always #5 clk = ~clk;

    literal_set_unit u0 (
        .clk(clk), .rst(rst), .deck_valid(deck_valid), .deck_shift(deck_shift),
        .deck_src(deck_src), .deck_dst(deck_dst), .deck_lit(deck_lit), .exec(exec),
        .outer_cnt(outer_cnt), .inner_cnt(inner_cnt), .inner_forever(inner_forever),
        .ack_route(ack_route), .word_reg(word_reg), .word_loaded(word_loaded),
        .unseal(unseal), .flag_we(flag_we), .flag_table(flag_table)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " outer_cnt"},     64'(outer_cnt),     64'(m_outer));
        chk({tag, " inner_cnt"},     64'(inner_cnt),     64'(m_inner));
        chk({tag, " inner_forever"}, 64'(inner_forever), 64'(m_inf));
        chk({tag, " ack_route"},     64'(ack_route),     64'(m_ack));
        chk({tag, " word_reg"},      64'(word_reg),      64'(m_word));
        chk({tag, " flag_table"},    64'(flag_table),    64'(m_flags));
        chk({tag, " R9 word_loaded"}, 64'(word_loaded),  64'(e_load));
        chk({tag, " R10 unseal"},    64'(unseal),        64'(e_unseal));
        chk({tag, " R8 flag_we"},    64'(flag_we),       64'(e_flag));
    endtask

    // Expected state after one execute, from the requirement rules.
    task automatic model(input logic sh, input logic [1:0] src, input logic [1:0] dst,
                         input logic [18:0] lit);
        e_load = 1'b0; e_unseal = 1'b0; e_flag = 1'b0;
        if (sh) begin
            m_word = {m_word[17:0], lit};
            e_load = 1'b1;
        end else if (src != 2'd3) begin
            case (dst)
                2'd0: begin
                    if (src == 2'd0)      m_outer = lit[5:0];
                    else if (src == 2'd1) m_outer = m_word[5:0];
                    else                  m_outer = (m_outer == 6'd0) ? 6'd0 : m_outer - 6'd1;
                    e_unseal = (m_outer == 6'd0);
                end
                2'd1: begin
                    if (src == 2'd2) begin m_inf = 1'b1; m_inner = 6'd0; end
                    else begin
                        m_inf   = 1'b0;
                        m_inner = (src == 2'd0) ? lit[5:0] : m_word[5:0];
                    end
                end
                2'd2: begin
                    if (src == 2'd0) m_ack = lit[12:0];
                    else begin
                        m_word = {(src == 2'd2) ? 22'h3FFFFF : 22'h0, lit[14:0]};
                        e_load = 1'b1;
                    end
                end
                default: begin m_flags = lit[11:0]; e_flag = 1'b1; end
            endcase
        end
    endtask

    function automatic string tag_of(input logic sh, input logic [1:0] src, input logic [1:0] dst);
        if (sh) return "R7";
        if (src == 2'd3) return "R11";
        case (dst)
            2'd0: return "R3";
            2'd1: return "R4";
            2'd2: return (src == 2'd0) ? "R5" : "R6";
            default: return "R8";
        endcase
    endfunction

    task automatic run(input logic sh, input logic [1:0] src, input logic [1:0] dst,
                       input logic [18:0] lit);
        @(negedge clk);
        deck_valid = 1'b1; deck_shift = sh; deck_src = src; deck_dst = dst; deck_lit = lit;
        @(negedge clk);
        deck_valid = 1'b0; deck_lit = ~lit; exec = 1'b1;
        model(sh, src, dst, lit);
        @(negedge clk);
        exec = 1'b0;
        check_all(tag_of(sh, src, dst));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [18:0] pats [4];
        pats[0] = 19'h7FFFF; pats[1] = 19'h2A5C3; pats[2] = 19'h00000; pats[3] = 19'h15A5A;
        rst = 1'b1; deck_valid = 1'b0; deck_shift = 1'b0; deck_src = 2'd0;
        deck_dst = 2'd0; deck_lit = '0; exec = 1'b0;
        m_outer = 0; m_inner = 0; m_inf = 0; m_ack = 0; m_word = 0; m_flags = 0;
        e_load = 0; e_unseal = 0; e_flag = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check_all("R1");

        // Sweep of every code pair with several literals.
        for (int p = 0; p < 4; p++)
            for (int s = 0; s < 4; s++)
                for (int d = 0; d < 4; d++)
                    run(1'b0, 2'(s), 2'(d), pats[p] ^ 19'(s * 7 + d));

        // R3 / R10: decrement down to zero and past it.
        run(1'b0, 2'd0, 2'd0, 19'd2);
        run(1'b0, 2'd2, 2'd0, 19'd0);
        run(1'b0, 2'd2, 2'd0, 19'd0);
        run(1'b0, 2'd2, 2'd0, 19'd0);

        // R6 then R3/R4 from the word register, then R4 infinity.
        run(1'b0, 2'd1, 2'd2, 19'h00025);
        run(1'b0, 2'd1, 2'd0, 19'h0003F);
        run(1'b0, 2'd1, 2'd1, 19'h0003F);
        run(1'b0, 2'd2, 2'd1, 19'h00011);

        // R7: build a wide constant with consecutive shifts.
        run(1'b0, 2'd1, 2'd2, 19'h00000);
        run(1'b1, 2'd0, 2'd0, 19'h5A5A5);
        run(1'b1, 2'd3, 2'd3, 19'h3C3C3);
        run(1'b1, 2'd0, 2'd0, 19'h7FFFF);

        // R12: stage without execute changes nothing.
        @(negedge clk);
        deck_valid = 1'b1; deck_shift = 1'b0; deck_src = 2'd0; deck_dst = 2'd2; deck_lit = 19'h01234;
        @(negedge clk);
        deck_valid = 1'b0;
        e_load = 0; e_unseal = 0; e_flag = 0;
        repeat (2) @(negedge clk);
        check_all("R12");

        // R2: stage A, stage B in the cycle A executes, then execute B.
        @(negedge clk);
        deck_valid = 1'b1; deck_shift = 1'b0; deck_src = 2'd0; deck_dst = 2'd0; deck_lit = 19'h00009;
        @(negedge clk);
        deck_src = 2'd0; deck_dst = 2'd1; deck_lit = 19'h00015; exec = 1'b1;
        model(1'b0, 2'd0, 2'd0, 19'h00009);
        @(negedge clk);
        deck_valid = 1'b0; deck_lit = 19'h7FFFF;
        check_all("R2 overlap first");
        model(1'b0, 2'd0, 2'd1, 19'h00015);
        @(negedge clk);
        exec = 1'b0;
        check_all("R2 overlap second");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule